// File: doc/BRIEF.md
# Transmit Burst Sequencer with Envelope Ramp

This block sequences the transmit side of a baseband modulator. When the power enable goes high it runs a fixed calibration wait, then raises `ready`. A burst request, taken only while `ready` is high, clears the symbol encoder, starts a bit clock divided from the master clock, and drives an 8-bit envelope gain. The gain rises over the first three symbols of the burst along a raised-cosine curve. When the burst request drops, the sequencer finishes the symbol in progress and then runs four more symbols. Over the first three of those the envelope falls along the mirrored curve, and it holds zero through the fourth. After that the block returns to `ready`.

One symbol is two bits, which is 128 master clocks. The bit clock is 64 master clocks long: 32 high, then 32 low. The downstream serializer latches transmit data on a one-cycle strobe that follows each falling edge of the bit clock. A separate output repeats the raw burst request after a fixed pipeline delay, so the RF amplifier switches in step with the output waveform. The reset input is asynchronous and active low. Its release is synchronized inside the block, which takes two clock edges.

Top module: `tx_burst_seq`

## Requirements
- R1: While reset is asserted, and in every cycle after an edge that sampled `power_en` low, `ready`, `bit_clk`, `bit_sample`, `enc_clear` and `env_gain` are all 0. While reset is asserted `burst_out` is also 0.
- R2: Count the first edge that samples `power_en` high as edge 1. `ready` is high after edge CAL_CYCLES+1 (4097) and low before it. If `power_en` is sampled low during the wait, the count starts over.
- R3: An edge that samples `burst_in` high while `ready` is high drops `ready` and raises `enc_clear` for START_DLY (3) cycles. `burst_in` has no effect in any other state, including a rise during the ramp-down tail.
- R4: `bit_clk` first goes high START_DLY edges after the edge that dropped `ready`. It then repeats 32 cycles high and 32 cycles low for the whole burst.
- R5: `bit_sample` is high for exactly the one cycle after each falling edge of `bit_clk`, which is cycle 32 of every 64-cycle bit period.
- R6: Number the cycles from t=0, the first cycle with `bit_clk` high. For t<384, the up gain is round(127.5·(1−cos(π·k/24))) with k = floor(t/16). From t=384 on, the up gain is 255.
- R7: Symbols are 128-cycle windows that start at t=0. After `burst_in` is sampled low, the current symbol completes and ends at cycle t0. Over [t0, t0+384) the down gain is round(127.5·(1−cos(π·(24−j)/24))) with j = floor((t−t0)/16). Over [t0+384, t0+512) the gain is 0. `bit_clk` keeps running until t0+512, and `ready` is high from that cycle on.
- R8: `env_gain` is the lower of the up gain and the down gain. This covers a burst that ends before its ramp-up has finished.
- R9: `burst_out` equals the value `burst_in` had BOUT_DLY (480) cycles earlier.
- R10: If `power_en` is sampled low during a burst, the burst is abandoned with all outputs as in R1. A full calibration wait must pass before `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_en | input | 1 | Transmit power enable, sampled each edge |
| burst_in | input | 1 | Burst request level |
| ready | output | 1 | Calibrated and idle, a burst may start |
| bit_clk | output | 1 | Divided transmit bit clock |
| bit_sample | output | 1 | Strobe for latching a data bit, in the cycle after the bit clock falls |
| enc_clear | output | 1 | Clears the phase encoder to the all-zero symbol before a burst |
| env_gain | output | 8 | Envelope gain, 255 is full scale |
| burst_out | output | 1 | Burst request delayed by the pipeline depth |

## Verification
The hardest cases to reach are the ones where the burst request falls at an awkward point in the symbol grid. One is a fall on the final cycle of a symbol, where the tail count has to start one symbol ahead. Another is a fall during the ramp-up, where the rising and falling envelopes overlap. The stimulus table places the drop cycle exactly, at t=127, t=200, t=640 and t=1000, counted from the first bit-clock cycle. It compares every output in every cycle of each burst against a model built from cosines. One entry also pulses the request during the tail, to show that the tail runs to its end unchanged.

// File: rtl/tx_burst_pkg.sv
package tx_burst_pkg;

  localparam int BIT_HALF      = 32;
  localparam int BIT_CLKS      = 2 * BIT_HALF;
  localparam int SYM_CLKS      = 2 * BIT_CLKS;
  localparam int STEP_CLKS     = 16;
  localparam int STEPS_PER_SYM = SYM_CLKS / STEP_CLKS;
  localparam int RAMP_SYMS     = 3;
  localparam int TAIL_SYMS     = 4;
  localparam int RAMP_STEPS    = RAMP_SYMS * STEPS_PER_SYM;
  localparam int GAIN_W        = 8;
  localparam int SP_W          = $clog2(SYM_CLKS);
  localparam int BP_W          = $clog2(BIT_CLKS);
  localparam int STEP_W        = $clog2(STEPS_PER_SYM);
  localparam int IDX_W         = $clog2(RAMP_STEPS + 1);
  localparam int US_W          = $clog2(RAMP_SYMS + 1);
  localparam int TS_W          = $clog2(TAIL_SYMS + 1);

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_CAL,
    ST_RDY,
    ST_START,
    ST_RUN,
    ST_TAIL
  } seq_state_e;

  // Rising raised-cosine gain, 255 * (1 - cos(pi*k/24)) / 2, rounded.
  function automatic logic [GAIN_W-1:0] ramp_lut(input logic [IDX_W-1:0] idx);
    logic [GAIN_W-1:0] r;
    case (idx)
      5'd0:    r = 8'd0;
      5'd1:    r = 8'd1;
      5'd2:    r = 8'd4;
      5'd3:    r = 8'd10;
      5'd4:    r = 8'd17;
      5'd5:    r = 8'd26;
      5'd6:    r = 8'd37;
      5'd7:    r = 8'd50;
      5'd8:    r = 8'd64;
      5'd9:    r = 8'd79;
      5'd10:   r = 8'd95;
      5'd11:   r = 8'd111;
      5'd12:   r = 8'd128;
      5'd13:   r = 8'd144;
      5'd14:   r = 8'd160;
      5'd15:   r = 8'd176;
      5'd16:   r = 8'd191;
      5'd17:   r = 8'd205;
      5'd18:   r = 8'd218;
      5'd19:   r = 8'd229;
      5'd20:   r = 8'd238;
      5'd21:   r = 8'd245;
      5'd22:   r = 8'd251;
      5'd23:   r = 8'd254;
      default: r = 8'd255;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tx_burst_ctrl.sv
module tx_burst_ctrl
  import tx_burst_pkg::*;
#(
  parameter int CAL_CYCLES = 4096,
  parameter int START_DLY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_en,
  input  logic              burst_in,
  output logic              ready,
  output logic              bit_clk,
  output logic              bit_sample,
  output logic              enc_clear,
  output logic              active,
  output logic [STEP_W-1:0] ramp_step,
  output logic [US_W-1:0]   up_sym,
  output logic [TS_W-1:0]   tail_sym
);

  localparam int CNT_MAX = (CAL_CYCLES > START_DLY) ? CAL_CYCLES : START_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [US_W-1:0]   us_q, us_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic              sym_end;
  logic              in_burst;

  assign sym_end  = (sp_q == SP_W'(SYM_CLKS - 1));
  assign in_burst = (state_q == ST_RUN) || (state_q == ST_TAIL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sp_d    = sp_q;
    us_d    = us_q;
    ts_d    = ts_q;
    unique case (state_q)
      ST_SLEEP: begin
        if (power_en) begin
          state_d = ST_CAL;
          cnt_d   = '0;
        end
      end
      ST_CAL: begin
        if (cnt_q == CNT_W'(CAL_CYCLES - 1)) state_d = ST_RDY;
        else                                  cnt_d   = cnt_q + 1'b1;
      end
      ST_RDY: begin
        if (burst_in) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (cnt_q == CNT_W'(START_DLY - 1)) begin
          state_d = ST_RUN;
          sp_d    = '0;
          us_d    = '0;
          ts_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN, ST_TAIL: begin
        sp_d = sp_q + 1'b1;
        if (sym_end && (us_q != US_W'(RAMP_SYMS))) us_d = us_q + 1'b1;
        if (state_q == ST_RUN) begin
          if (!burst_in) begin
            state_d = ST_TAIL;
            ts_d    = sym_end ? TS_W'(1) : '0;
          end
        end else if (sym_end) begin
          if (ts_q == TS_W'(TAIL_SYMS)) state_d = ST_RDY;
          else                          ts_d    = ts_q + 1'b1;
        end
      end
      default: state_d = ST_SLEEP;
    endcase
    if (!power_en) state_d = ST_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      cnt_q   <= '0;
      sp_q    <= '0;
      us_q    <= '0;
      ts_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sp_q    <= sp_d;
      us_q    <= us_d;
      ts_q    <= ts_d;
    end
  end

  assign ready      = (state_q == ST_RDY);
  assign enc_clear  = (state_q == ST_START);
  assign active     = in_burst;
  assign bit_clk    = in_burst && (sp_q[BP_W-1:0] < BP_W'(BIT_HALF));
  assign bit_sample = in_burst && (sp_q[BP_W-1:0] == BP_W'(BIT_HALF));
  assign ramp_step  = sp_q[SP_W-1 -: STEP_W];
  assign up_sym     = us_q;
  assign tail_sym   = ts_q;

  p_sleep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !power_en |=> (!ready && !active && !enc_clear));

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && burst_in && power_en) |=> (!ready && enc_clear));

  p_clk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |-> !ready);

  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sample |-> $fell(bit_clk));

endmodule

// File: rtl/tx_ramp_env.sv
module tx_ramp_env
  import tx_burst_pkg::*;
(
  input  logic              active,
  input  logic [STEP_W-1:0] ramp_step,
  input  logic [US_W-1:0]   up_sym,
  input  logic [TS_W-1:0]   tail_sym,
  output logic [GAIN_W-1:0] gain
);

  logic [IDX_W-1:0]  up_idx, dn_idx;
  logic [GAIN_W-1:0] up_g, dn_g;

  always_comb begin
    if (up_sym >= US_W'(RAMP_SYMS)) up_idx = IDX_W'(RAMP_STEPS);
    else up_idx = IDX_W'(up_sym) * IDX_W'(STEPS_PER_SYM) + IDX_W'(ramp_step);
    up_g = ramp_lut(up_idx);

    dn_idx = '0;
    if (tail_sym == '0) begin
      dn_g = '1;
    end else if (tail_sym <= TS_W'(RAMP_SYMS)) begin
      dn_idx = IDX_W'(tail_sym - TS_W'(1)) * IDX_W'(STEPS_PER_SYM) + IDX_W'(ramp_step);
      dn_g   = ramp_lut(IDX_W'(RAMP_STEPS) - dn_idx);
    end else begin
      dn_g = '0;
    end

    if (!active)          gain = '0;
    else if (up_g < dn_g) gain = up_g;
    else                  gain = dn_g;
  end

endmodule

// File: rtl/tx_delay_line.sv
module tx_delay_line #(
  parameter int DEPTH = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else if (DEPTH == 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= 1'b0;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_shift
      logic [DEPTH-1:0] sh_q, sh_d;
      assign sh_d = {sh_q[DEPTH-2:0], d};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
      assign q = sh_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/tx_burst_seq.sv
module tx_burst_seq
  import tx_burst_pkg::*;
#(
  parameter int CAL_CYCLES = 4096,
  parameter int START_DLY  = 3,
  parameter int BOUT_DLY   = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_en,
  input  logic              burst_in,
  output logic              ready,
  output logic              bit_clk,
  output logic              bit_sample,
  output logic              enc_clear,
  output logic [GAIN_W-1:0] env_gain,
  output logic              burst_out
);

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic              active;
  logic [STEP_W-1:0] ramp_step;
  logic [US_W-1:0]   up_sym;
  logic [TS_W-1:0]   tail_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  tx_burst_ctrl #(
    .CAL_CYCLES (CAL_CYCLES),
    .START_DLY  (START_DLY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .power_en   (power_en),
    .burst_in   (burst_in),
    .ready      (ready),
    .bit_clk    (bit_clk),
    .bit_sample (bit_sample),
    .enc_clear  (enc_clear),
    .active     (active),
    .ramp_step  (ramp_step),
    .up_sym     (up_sym),
    .tail_sym   (tail_sym)
  );

  tx_ramp_env u_env (
    .active    (active),
    .ramp_step (ramp_step),
    .up_sym    (up_sym),
    .tail_sym  (tail_sym),
    .gain      (env_gain)
  );

  tx_delay_line #(
    .DEPTH (BOUT_DLY)
  ) u_bout (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (burst_in),
    .q     (burst_out)
  );

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && $past(active) && (tail_sym == '0)) |-> (env_gain >= $past(env_gain)));

  p_idle_gain_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> (env_gain == '0));

endmodule

// File: tb/tx_burst_seq_bench.sv
module tx_burst_seq_bench;

  localparam int CAL = 4096;
  localparam int DLY = 480;
  localparam int NSC = 4;
  localparam int DROP_AT [NSC] = '{1000, 200, 127, 640};
  localparam bit REBUMP  [NSC] = '{1'b1, 1'b0, 1'b0, 1'b0};

  logic       clk, rst_n, power_en, burst_in;
  logic       ready, bit_clk, bit_sample, enc_clear, burst_out;
  logic [7:0] env_gain;

  int checks, fails, cyc;
  bit done;
  logic hist [512];

  tx_burst_seq u_tx_burst_seq (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .burst_in(burst_in),
    .ready(ready), .bit_clk(bit_clk), .bit_sample(bit_sample),
    .enc_clear(enc_clear), .env_gain(env_gain), .burst_out(burst_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    hist[cyc % 512] = burst_in;
  endtask

  task automatic set_bin(input logic v);
    burst_in = v;
    hist[cyc % 512] = v;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input int act, input int exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      fails++;
      $display("FAIL %s env_gain cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic int rc(input int k);
    real v;
    v = 127.5 * (1.0 - $cos(3.14159265358979 * k / 24.0));
    return $rtoi(v + 0.5);
  endfunction

  task automatic calibrate(input string req);
    power_en = 1'b1;
    repeat (CAL) tick();
    chk(req, "ready before wait ends", int'(ready), 0);
    tick();
    chk(req, "ready after wait", int'(ready), 1);
  endtask

  task automatic run_burst(input int td, input bit bump);
    int t0, tend, up, dn, eg;
    bit act;
    string rq;
    t0   = (td / 128 + 1) * 128;
    tend = t0 + 512;
    set_bin(1'b1);
    tick();
    chk("R3", "ready after accept", int'(ready), 0);
    chk("R3", "enc_clear 1", int'(enc_clear), 1);
    tick();
    tick();
    chk("R3", "enc_clear 3", int'(enc_clear), 1);
    chk("R4", "bit_clk before start", int'(bit_clk), 0);
    tick();
    for (int t = 0; t <= tend + 1; t++) begin
      act = (t < tend);
      up  = (t >= 384) ? 255 : rc(t / 16);
      if (t < t0)            dn = 255;
      else if (t < t0 + 384) dn = rc(24 - (t - t0) / 16);
      else                   dn = 0;
      eg = act ? ((up < dn) ? up : dn) : 0;
      rq = (t >= t0) ? "R7" : "R6";
      if (td < 384 && t >= t0 && t < 384) rq = "R8";
      if (bump && t >= t0 + 100 && t < tend) rq = "R3";
      chk_tol(rq, int'(env_gain), eg);
      chk((t >= t0) ? "R7" : "R4", "bit_clk", int'(bit_clk), int'(act && (t % 64) < 32));
      chk("R5", "bit_sample", int'(bit_sample), int'(act && (t % 64) == 32));
      chk(rq, "ready", int'(ready), int'(t >= tend));
      chk("R9", "burst_out", int'(burst_out), int'(hist[(cyc - DLY) % 512]));
      if (t == td) set_bin(1'b0);
      if (bump && t == t0 + 100) set_bin(1'b1);
      if (bump && t == t0 + 110) set_bin(1'b0);
      tick();
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; done = 1'b0;
    for (int i = 0; i < 512; i++) hist[i] = 1'b0;
    rst_n = 1'b0; power_en = 1'b0; burst_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "bit_clk in reset", int'(bit_clk), 0);
    chk("R1", "gain in reset", int'(env_gain), 0);
    chk("R1", "enc_clear in reset", int'(enc_clear), 0);
    chk("R1", "burst_out in reset", int'(burst_out), 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R1", "ready while power low", int'(ready), 0);
    chk("R1", "bit_sample while power low", int'(bit_sample), 0);

    // calibration interrupted by one low sample restarts from zero
    power_en = 1'b1;
    repeat (100) tick();
    power_en = 1'b0;
    tick();
    chk("R2", "ready after abort", int'(ready), 0);
    calibrate("R2");

    // table of burst scenarios
    for (int i = 0; i < NSC; i++) begin
      run_burst(DROP_AT[i], REBUMP[i]);
      chk("R7", "ready between bursts", int'(ready), 1);
    end

    // power drop during a live burst
    set_bin(1'b1);
    repeat (204) tick();
    chk("R10", "bit_clk mid burst", int'(bit_clk), 1);
    power_en = 1'b0;
    tick();
    chk("R10", "bit_clk after power drop", int'(bit_clk), 0);
    chk("R10", "gain after power drop", int'(env_gain), 0);
    chk("R10", "ready after power drop", int'(ready), 0);
    chk("R10", "enc_clear after power drop", int'(enc_clear), 0);
    set_bin(1'b0);
    tick();
    calibrate("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule